// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single hardware counting semaphore for a multi-threaded processor cluster. It keeps a 16-bit count and serves two request channels in the same cycle: a read channel, which carries an access mode code and the ID of the requesting thread, and a write channel, which carries an access mode code and a data word. In the two semaphore modes a read performs the P operation and a write performs the V operation. A read takes a unit from the count and returns the value the count held before the decrement. A write adds one to the count and stops at the maximum.

A read in the waiting semaphore mode that finds no unit available answers "blocked" and parks the thread in an internal mask. The next V releases every parked thread at once with a one-cycle wake pulse per thread, and each woken thread is expected to retry its P. A P and a V that arrive in the same cycle are resolved as the V first and then the P. Raw mode reads return the count. Queue-style modes, the control mode and unused codes have no effect on a semaphore cell. All responses are registered and appear one cycle after the request.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, no thread is parked, all outputs are 0, and a read with mode code 1 (control) returns 0, so the queue-kind flag at bit 17 reads 0 (the cell is a semaphore).
- R2: A read with mode code 4 (P, waiting) or 5 (P, non-waiting) on a nonzero count returns the count before the operation and lowers the count by one.
- R3: A read with mode code 5 on a zero count returns 0, does not block, and leaves the count at 0.
- R4: A read with mode code 4 on a zero count returns 0 with the blocked flag set, leaves the count at 0, and parks the requesting thread ID in the blocked mask.
- R5: A write with mode code 4 or 5 (V) raises the count by one and holds it at 0xFFFF when it is already there. The written data is ignored.
- R6: One cycle after a V, the wake output pulses for one cycle with a bit set for every parked thread (bit n = thread ID n), and the blocked mask is emptied. A V with no parked thread gives no pulse.
- R7: A read with mode code 0 (raw) returns the count and does not change it. A write with mode code 0 is ignored.
- R8: Reads with mode codes 2 and 3 (queue modes), 1 and 6 to 15 return 0 and change nothing. Writes with these codes are ignored.
- R9: When a P and a V arrive in the same cycle, the V applies first (with saturation) and the P then sees the raised count, so it never blocks. A raw read in the same cycle as a V also sees the raised count.
- R10: Read acknowledge, read data and blocked flag are valid one cycle after the read request. Read data and blocked flag are 0 in cycles without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | Read request present |
| rdView | input | 4 | Mode code of the read |
| rdThread | input | 3 | ID of the requesting thread |
| wrValid | input | 1 | Write request present |
| wrView | input | 4 | Mode code of the write |
| wrData | input | 32 | Write data (not used by the semaphore) |
| rdAck | output | 1 | Read response valid |
| rdData | output | 32 | Read response data |
| rdBlocked | output | 1 | Read response: thread was parked |
| wakeMask | output | 8 | One-cycle wake pulse, one bit per thread |

## Verification
The P on the read channel and the V on the write channel can land in the same cycle. The bench provokes this by driving both channels together, first with threads parked on a zero count, where the read must return 1 without blocking while the wake pulse names exactly the parked threads, and again at a count of 0xFFFE and at the saturated count, where the read must return 0xFFFF and the count must settle one below it. A raw read paired with a V checks that reads observe the count after the V.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

  localparam logic [3:0] VIEW_RAW     = 4'd0;
  localparam logic [3:0] VIEW_CTRL    = 4'd1;
  localparam logic [3:0] VIEW_Q_WAIT  = 4'd2;
  localparam logic [3:0] VIEW_Q_TRY   = 4'd3;
  localparam logic [3:0] VIEW_PV_WAIT = 4'd4;
  localparam logic [3:0] VIEW_PV_TRY  = 4'd5;

  typedef enum logic {
    SEL_ZERO  = 1'b0,
    SEL_COUNT = 1'b1
  } rdSel_e;

  typedef struct packed {
    logic   inc;
    logic   dec;
    logic   block;
    logic   wake;
    logic   ack;
    rdSel_e sel;
  } semStrobe_t;

endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_cell_pkg::*;
(
  input  logic       rdValid,
  input  logic [3:0] rdView,
  input  logic       wrValid,
  input  logic [3:0] wrView,
  input  logic       countZero,
  output semStrobe_t strb
);

  logic pRead;
  logic pWaitRead;
  logic rawRead;
  logic vWrite;
  logic emptyAfterV;

  always_comb begin
    pWaitRead   = rdValid && (rdView == VIEW_PV_WAIT);
    pRead       = pWaitRead || (rdValid && (rdView == VIEW_PV_TRY));
    rawRead     = rdValid && (rdView == VIEW_RAW);
    vWrite      = wrValid && ((wrView == VIEW_PV_WAIT) || (wrView == VIEW_PV_TRY));
    // the V is ordered before the P of the same cycle
    emptyAfterV = countZero && !vWrite;

    strb.inc   = vWrite;
    strb.wake  = vWrite;
    strb.dec   = pRead && !emptyAfterV;
    strb.block = pWaitRead && emptyAfterV;
    strb.ack   = rdValid;
    strb.sel   = (pRead || rawRead) ? SEL_COUNT : SEL_ZERO;
  end

endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_cell_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int DATA_W  = 32,
  parameter int THREADS = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  semStrobe_t         strb,
  input  logic [TID_W-1:0]   rdThread,
  output logic               countZero,
  output logic               rdAck,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdBlocked,
  output logic [THREADS-1:0] wakeMask
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] afterV;
  logic [COUNT_W-1:0] countNext;
  logic [THREADS-1:0] blockedMask;
  logic [THREADS-1:0] maskNext;

  always_comb begin
    afterV    = (strb.inc && (count != COUNT_MAX)) ? count + 1'b1 : count;
    countNext = strb.dec ? afterV - 1'b1 : afterV;
    maskNext  = strb.wake ? '0 : blockedMask;
    for (int t = 0; t < THREADS; t++) begin
      if (strb.block && (rdThread == TID_W'(t))) maskNext[t] = 1'b1;
    end
  end

  assign countZero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      blockedMask <= '0;
      rdAck       <= 1'b0;
      rdData      <= '0;
      rdBlocked   <= 1'b0;
      wakeMask    <= '0;
    end else begin
      count       <= countNext;
      blockedMask <= maskNext;
      rdAck       <= strb.ack;
      rdData      <= (strb.ack && strb.sel == SEL_COUNT) ? DATA_W'(afterV) : '0;
      rdBlocked   <= strb.block;
      wakeMask    <= strb.wake ? blockedMask : '0;
    end
  end

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == COUNT_MAX && strb.inc && !strb.dec) |=> (count == COUNT_MAX));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !strb.inc) |=> (count == '0));

  a_r2_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.dec && !strb.inc) |=> (count == $past(count) - 1'b1));

  a_r4_thread_parked: assert property (@(posedge clk) disable iff (!rst_n)
    strb.block |=> (blockedMask != '0));

  a_r6_mask_emptied: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wake && !strb.block) |=> (blockedMask == '0));

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_cell_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int DATA_W  = 32,
  parameter int THREADS = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rdValid,
  input  logic [3:0]         rdView,
  input  logic [TID_W-1:0]   rdThread,
  input  logic               wrValid,
  input  logic [3:0]         wrView,
  input  logic [DATA_W-1:0]  wrData,
  output logic               rdAck,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdBlocked,
  output logic [THREADS-1:0] wakeMask
);

  semStrobe_t strb;
  logic       countZero;
  logic       unusedData;

  assign unusedData = ^wrData;

  sem_ctrl i_ctrl (
    .rdValid   (rdValid),
    .rdView    (rdView),
    .wrValid   (wrValid),
    .wrView    (wrView),
    .countZero (countZero),
    .strb      (strb)
  );

  sem_datapath #(
    .COUNT_W (COUNT_W),
    .DATA_W  (DATA_W),
    .THREADS (THREADS)
  ) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .rdThread  (rdThread),
    .countZero (countZero),
    .rdAck     (rdAck),
    .rdData    (rdData),
    .rdBlocked (rdBlocked),
    .wakeMask  (wakeMask)
  );

  a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> rdAck);

  a_r4_blocked_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rdBlocked |-> (rdData == '0 && rdAck));

  a_r6_wake_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeMask != '0) |-> $past(wrValid));

  a_r9_no_block_with_v: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && wrValid && (wrView == VIEW_PV_WAIT || wrView == VIEW_PV_TRY)) |=> !rdBlocked);

endmodule

// File: tb/test_sem_cell.sv
module test_sem_cell;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdValid = 1'b0;
  logic [3:0]  rdView = '0;
  logic [2:0]  rdThread = '0;
  logic        wrValid = 1'b0;
  logic [3:0]  wrView = '0;
  logic [31:0] wrData = '0;
  logic        rdAck;
  logic [31:0] rdData;
  logic        rdBlocked;
  logic [7:0]  wakeMask;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sem_cell i_sem_cell (
    .clk(clk), .rst_n(rst_n), .rdValid(rdValid), .rdView(rdView),
    .rdThread(rdThread), .wrValid(wrValid), .wrView(wrView), .wrData(wrData),
    .rdAck(rdAck), .rdData(rdData), .rdBlocked(rdBlocked), .wakeMask(wakeMask)
  );

  typedef struct packed {
    logic        rv;
    logic [3:0]  rview;
    logic [2:0]  tid;
    logic        wv;
    logic [3:0]  wview;
    logic [31:0] expData;
    logic        expBlk;
    logic [7:0]  expWake;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd4, 3'd2, 1'b0, 4'd0, 32'd0, 1'b1, 8'h00, 8'd4},  // R4 park thread 2
    '{1'b1, 4'd5, 3'd3, 1'b0, 4'd0, 32'd0, 1'b0, 8'h00, 8'd3},  // R3 try at zero
    '{1'b1, 4'd0, 3'd0, 1'b0, 4'd0, 32'd0, 1'b0, 8'h00, 8'd7},  // R7 raw read 0
    '{1'b0, 4'd0, 3'd0, 1'b1, 4'd4, 32'd0, 1'b0, 8'h04, 8'd6},  // R6 V wakes thread 2
    '{1'b0, 4'd0, 3'd0, 1'b1, 4'd5, 32'd0, 1'b0, 8'h00, 8'd5},  // R5 count 2
    '{1'b1, 4'd0, 3'd0, 1'b0, 4'd0, 32'd2, 1'b0, 8'h00, 8'd7},  // R7
    '{1'b1, 4'd4, 3'd1, 1'b0, 4'd0, 32'd2, 1'b0, 8'h00, 8'd2},  // R2 count 1
    '{1'b1, 4'd5, 3'd1, 1'b0, 4'd0, 32'd1, 1'b0, 8'h00, 8'd2},  // R2 count 0
    '{1'b1, 4'd5, 3'd1, 1'b0, 4'd0, 32'd0, 1'b0, 8'h00, 8'd3},  // R3
    '{1'b1, 4'd2, 3'd0, 1'b1, 4'd2, 32'd0, 1'b0, 8'h00, 8'd8},  // R8 queue views
    '{1'b1, 4'd0, 3'd0, 1'b1, 4'd0, 32'd0, 1'b0, 8'h00, 8'd7},  // R7 raw write ignored
    '{1'b1, 4'd4, 3'd5, 1'b0, 4'd0, 32'd0, 1'b1, 8'h00, 8'd4},  // R4 park 5
    '{1'b1, 4'd4, 3'd7, 1'b0, 4'd0, 32'd0, 1'b1, 8'h00, 8'd4},  // R4 park 7
    '{1'b1, 4'd4, 3'd3, 1'b1, 4'd5, 32'd1, 1'b0, 8'hA0, 8'd9},  // R9 P+V at zero
    '{1'b1, 4'd0, 3'd0, 1'b0, 4'd0, 32'd0, 1'b0, 8'h00, 8'd9},  // R9 settled at 0
    '{1'b1, 4'd0, 3'd0, 1'b1, 4'd4, 32'd1, 1'b0, 8'h00, 8'd9},  // R9 raw sees V
    '{1'b1, 4'd1, 3'd0, 1'b0, 4'd0, 32'd0, 1'b0, 8'h00, 8'd8},  // R8 control
    '{1'b1, 4'd3, 3'd0, 1'b1, 4'd3, 32'd0, 1'b0, 8'h00, 8'd8},  // R8 queue try
    '{1'b1, 4'd0, 3'd0, 1'b0, 4'd0, 32'd1, 1'b0, 8'h00, 8'd8},  // R8 count kept
    '{1'b1, 4'd9, 3'd0, 1'b1, 4'd1, 32'd0, 1'b0, 8'h00, 8'd8},  // R8 unused code
    '{1'b1, 4'd0, 3'd0, 1'b0, 4'd0, 32'd1, 1'b0, 8'h00, 8'd8}   // R8 count kept
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [3:0] rview, input logic [2:0] tid,
                       input logic wv, input logic [3:0] wview, input logic [31:0] wd);
    rdValid = rv; rdView = rview; rdThread = tid;
    wrValid = wv; wrView = wview; wrData = wd;
  endtask

  task automatic idle();
    drive(1'b0, 4'd0, 3'd0, 1'b0, 4'd0, 32'd0);
  endtask

  // one request, result sampled at the next falling edge
  task automatic step(input logic rv, input logic [3:0] rview, input logic [2:0] tid,
                      input logic wv, input logic [3:0] wview);
    drive(rv, rview, tid, wv, wview, 32'hDEAD_BEEF);
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    idle();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1", "rdAck", {31'd0, rdAck}, 32'd0);
    chk("R1", "rdData", rdData, 32'd0);
    chk("R1", "wakeMask", {24'd0, wakeMask}, 32'd0);
    step(1'b1, 4'd1, 3'd0, 1'b0, 4'd0);
    chk("R1", "control view bit17", {31'd0, rdData[17]}, 32'd0);
    step(1'b1, 4'd0, 3'd0, 1'b0, 4'd0);
    chk("R1", "count after reset", rdData, 32'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].rv, VECS[i].rview, VECS[i].tid, VECS[i].wv, VECS[i].wview,
            32'hC0DE_0000 + i);
      @(negedge clk);
      tests++;
      if (rdData !== VECS[i].expData || rdBlocked !== VECS[i].expBlk ||
          wakeMask !== VECS[i].expWake || rdAck !== VECS[i].rv) begin
        fails++;
        $display("FAIL R%0d vec %0d: actual data=%0h blk=%0b wake=%0h ack=%0b expected data=%0h blk=%0b wake=%0h ack=%0b",
                 VECS[i].req, i, rdData, rdBlocked, wakeMask, rdAck,
                 VECS[i].expData, VECS[i].expBlk, VECS[i].expWake, VECS[i].rv);
      end
    end
    idle();
    @(negedge clk);
    // R10 pulse and data drop after the request ends
    chk("R10", "rdAck idle", {31'd0, rdAck}, 32'd0);
    chk("R10", "rdData idle", rdData, 32'd0);
    chk("R6", "wake one cycle", {24'd0, wakeMask}, 32'd0);

    // R1: reset empties the parked mask
    step(1'b1, 4'd4, 3'd0, 1'b0, 4'd0);   // count is 1: plain P
    step(1'b1, 4'd4, 3'd0, 1'b0, 4'd0);   // parks thread 0
    chk("R4", "park before reset", {31'd0, rdBlocked}, 32'd1);
    doReset();
    step(1'b0, 4'd0, 3'd0, 1'b1, 4'd4);
    chk("R1", "no wake after reset", {24'd0, wakeMask}, 32'd0);

    // R5 saturation: count is 1, raise to 0xFFFF
    for (int k = 0; k < 65534; k++) begin
      drive(1'b0, 4'd0, 3'd0, 1'b1, (k % 2 == 0) ? 4'd4 : 4'd5, 32'(k));
      @(negedge clk);
    end
    idle();
    step(1'b1, 4'd0, 3'd0, 1'b0, 4'd0);
    chk("R5", "count at max", rdData, 32'h0000_FFFF);
    step(1'b0, 4'd0, 3'd0, 1'b1, 4'd5);
    step(1'b1, 4'd0, 3'd0, 1'b0, 4'd0);
    chk("R5", "saturated", rdData, 32'h0000_FFFF);
    // R9 P+V at max: V saturates, P returns max, count max-1
    step(1'b1, 4'd5, 3'd6, 1'b1, 4'd4);
    chk("R9", "P+V at max", rdData, 32'h0000_FFFF);
    step(1'b1, 4'd0, 3'd0, 1'b0, 4'd0);
    chk("R9", "count after P+V at max", rdData, 32'h0000_FFFE);
    // R9 P+V at max-1
    step(1'b1, 4'd4, 3'd6, 1'b1, 4'd5);
    chk("R9", "P+V at max-1", rdData, 32'h0000_FFFF);
    step(1'b1, 4'd0, 3'd0, 1'b0, 4'd0);
    chk("R9", "count after P+V at max-1", rdData, 32'h0000_FFFE);
    // R2 plain P near max
    step(1'b1, 4'd5, 3'd4, 1'b0, 4'd0);
    chk("R2", "P returns prior", rdData, 32'h0000_FFFE);
    step(1'b1, 4'd0, 3'd0, 1'b0, 4'd0);
    chk("R2", "count lowered", rdData, 32'h0000_FFFD);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule